// File: doc/BRIEF.md
# SDRAM Command-Mode Register Executor

This block turns a single command word, written by software, into the pin activity that an SDR SDRAM device needs during bring-up and power management. The word selects a command mode and one or both chip-select banks. It also carries a repeat count, which applies to auto-refresh, and an address payload, which applies to the load-mode-register command. When a legal word is accepted, the block drives CKE, the chip selects, RAS_n/CAS_n/WE_n, the bank address and the address bus. It then keeps a busy flag raised until the command and its minimum spacing have elapsed.

Every chip-select bank supplies a packed timing word made of 4-bit fields. Each field holds the required cycle count minus one. When both banks are targeted, the block uses the larger value of each field. Software polls the busy bit in the status word before writing the next command. Any write that arrives while busy is high is dropped.

Top module: `sdram_cmd_exec`

## Requirements
- R1: After reset, both CKE outputs are low, both chip selects are high and busy is 0.
- R2: The command word packs several fields. Mode sits in bits [2:0], coded as 0 normal, 1 clock enable, 2 precharge-all, 3 auto-refresh, 4 load mode register, 5 self-refresh, 6 power-down. Bit 4 targets bank 1, which drives `sd_cs_n[0]`. Bit 3 targets bank 2, which drives `sd_cs_n[1]`. A command asserts only the chip selects of targeted banks.
- R3: Precharge-all drives RAS_n=0, CAS_n=1, WE_n=0 and address bit 10 high for one cycle. Busy stays high for tRP+1 cycles, where tRP is timing bits [23:20].
- R4: Auto-refresh issues N+1 refresh commands (RAS_n=0, CAS_n=0, WE_n=1, CKE high), where N is command bits [8:5]. Consecutive refreshes start tRC+1 cycles apart, where tRC is timing bits [15:12]. Busy falls tRC+1 cycles after the last refresh.
- R5: Load mode register drives RAS_n, CAS_n and WE_n all low and bank address 0. It places command bits [9+ADDR_W-1:9] on the address bus, with burst length in payload bits [2:0] and CAS latency from payload bit 4. Busy lasts tMRD+1 cycles, where tMRD is timing bits [3:0].
- R6: Clock enable and normal modes set CKE high on the targeted banks and put a NOP (chip select low, RAS_n/CAS_n/WE_n high) on the pins. Busy lasts one cycle.
- R7: Self-refresh drives CKE low on the targeted banks in the same cycle as a refresh strobe pattern. Power-down drives CKE low with a NOP. CKE of untargeted banks is unchanged.
- R8: Whenever no command is being issued, both chip selects are high.
- R9: A write that arrives while busy is high has no effect on the pins, the busy duration or the command state.
- R10: A mode value of 7, or a word that targets no bank, is a no-op. It does not raise busy and it leaves the pins idle.
- R11: When both banks are targeted, every spacing uses the larger of the two banks' fields.
- R12: The status word shows busy at bit 5, and all other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 32 | Command word |
| tim_bank1 | input | 28 | Packed timing fields for bank 1 |
| tim_bank2 | input | 28 | Packed timing fields for bank 2 |
| status | output | 32 | Status word, busy at bit 5 |
| sd_cke | output | 2 | Clock enable per bank |
| sd_cs_n | output | 2 | Chip select per bank, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address bus |

## Verification
The assertions assume that the timing inputs hold steady while a command is in flight, because the spacing is captured only when a word is accepted. They also assume that the address width is wide enough to contain bit 10. The stimulus changes the timing words only at reset, and it issues every write on the falling edge for exactly one cycle. Some tests deliberately write while busy or write illegal words, so that the drop and no-op paths run under the same assertions.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int WORD_W   = 32;
    localparam int FIELD_W  = 4;
    localparam int NFIELD   = 7;
    localparam int TIM_W    = FIELD_W * NFIELD;
    localparam int NCS      = 2;
    localparam int REP_LSB  = 5;
    localparam int PAY_LSB  = 9;
    localparam int PAY_W    = WORD_W - PAY_LSB;
    localparam int BANK1_BIT = 4;
    localparam int BANK2_BIT = 3;
    localparam int BUSY_BIT = 5;
    localparam int AP_BIT   = 10;

    typedef enum logic [2:0] {
        MD_NORMAL = 3'd0,
        MD_CLKEN  = 3'd1,
        MD_PREALL = 3'd2,
        MD_AREF   = 3'd3,
        MD_LMR    = 3'd4,
        MD_SELF   = 3'd5,
        MD_PDOWN  = 3'd6,
        MD_BAD    = 3'd7
    } mode_e;

    typedef struct packed {
        logic [PAY_W-1:0]   payload;
        logic [FIELD_W-1:0] reps;
        logic [NCS-1:0]     mask;
        mode_e              mode;
    } cmd_s;

    typedef struct packed {
        logic [FIELD_W-1:0] t_rcd;
        logic [FIELD_W-1:0] t_rp;
        logic [FIELD_W-1:0] t_wr;
        logic [FIELD_W-1:0] t_rc;
        logic [FIELD_W-1:0] t_ras;
        logic [FIELD_W-1:0] t_xsr;
        logic [FIELD_W-1:0] t_mrd;
    } timing_s;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_s;

    function automatic cmd_s unpack_word(input logic [WORD_W-1:0] w);
        cmd_s c;
        c.mode    = mode_e'(w[2:0]);
        c.mask    = {w[BANK2_BIT], w[BANK1_BIT]};
        c.reps    = w[REP_LSB +: FIELD_W];
        c.payload = w[PAY_LSB +: PAY_W];
        return c;
    endfunction

    function automatic logic [FIELD_W-1:0] fmax(input logic [FIELD_W-1:0] a,
                                                input logic [FIELD_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [FIELD_W-1:0] gap_of(input mode_e m, input timing_s t);
        case (m)
            MD_PREALL: return t.t_rp;
            MD_AREF:   return t.t_rc;
            MD_LMR:    return t.t_mrd;
            default:   return '0;
        endcase
    endfunction

    function automatic strobe_s strobe_of(input mode_e m);
        case (m)
            MD_PREALL: return '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            MD_AREF,
            MD_SELF:   return '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            MD_LMR:    return '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            default:   return '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic [WORD_W-1:0]  word,
    input  logic [TIM_W-1:0]   tim_b1,
    input  logic [TIM_W-1:0]   tim_b2,
    output cmd_s               cmd,
    output logic               legal,
    output logic [FIELD_W-1:0] gap
);
    logic [TIM_W-1:0] merged;
    timing_s          tsel;

    assign cmd = unpack_word(word);

    // Per-field maximum over the targeted banks
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        logic [FIELD_W-1:0] fa, fb;
        assign fa = cmd.mask[0] ? tim_b1[f*FIELD_W +: FIELD_W] : '0;
        assign fb = cmd.mask[1] ? tim_b2[f*FIELD_W +: FIELD_W] : '0;
        assign merged[f*FIELD_W +: FIELD_W] = fmax(fa, fb);
    end

    assign tsel  = timing_s'(merged);
    assign gap   = gap_of(cmd.mode, tsel);
    assign legal = (cmd.mode != MD_BAD) && (cmd.mask != '0);

endmodule

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
    import sdcmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               legal,
    input  cmd_s               cmd_in,
    input  logic [FIELD_W-1:0] gap_in,
    output logic               issue,
    output cmd_s               issue_cmd,
    output logic               busy
);
    cmd_s               cmd_q;
    logic [FIELD_W-1:0] gap_q;
    logic [FIELD_W-1:0] cnt_q;
    logic [FIELD_W-1:0] rep_q;
    logic               busy_q;
    logic               accept;
    logic               again;

    assign accept    = wr_en && !busy_q && legal;
    assign again     = busy_q && (cnt_q == '0) && (rep_q != '0);
    assign issue     = accept || again;
    assign issue_cmd = accept ? cmd_in : cmd_q;
    assign busy      = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cmd_q  <= '{payload: '0, reps: '0, mask: '0, mode: MD_NORMAL};
            gap_q  <= '0;
            cnt_q  <= '0;
            rep_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            cmd_q  <= cmd_in;
            gap_q  <= gap_in;
            cnt_q  <= gap_in;
            rep_q  <= (cmd_in.mode == MD_AREF) ? cmd_in.reps : '0;
        end else if (busy_q) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (rep_q != '0) begin
                rep_q <= rep_q - 1'b1;
                cnt_q <= gap_q;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && wr_en) |=> $stable(cmd_q));

    p_noop_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && wr_en && !legal) |=> !busy_q);

    p_repeat_inbusy_r4: assert property (@(posedge clk) disable iff (rst)
        (rep_q != '0) |-> busy_q);

endmodule

// File: rtl/sdcmd_pins.sv
module sdcmd_pins
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  cmd_s              cmd,
    output logic [NCS-1:0]    cke,
    output logic [NCS-1:0]    cs_n,
    output strobe_s           strb,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_nxt;
    logic [NCS-1:0]    cke_nxt;

    always_comb begin
        addr_nxt = '0;
        if (cmd.mode == MD_LMR)
            addr_nxt = cmd.payload[ADDR_W-1:0];
        else if (cmd.mode == MD_PREALL)
            addr_nxt[AP_BIT] = 1'b1;
    end

    for (genvar b = 0; b < NCS; b++) begin : g_cke
        always_comb begin
            cke_nxt[b] = cke[b];
            if (cmd.mask[b]) begin
                case (cmd.mode)
                    MD_NORMAL, MD_CLKEN: cke_nxt[b] = 1'b1;
                    MD_SELF, MD_PDOWN:   cke_nxt[b] = 1'b0;
                    default:             cke_nxt[b] = cke[b];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke  <= '0;
            cs_n <= '1;
            strb <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            ba   <= '0;
            addr <= '0;
        end else if (issue) begin
            cke  <= cke_nxt;
            cs_n <= ~cmd.mask;
            strb <= strobe_of(cmd.mode);
            ba   <= '0;
            addr <= addr_nxt;
        end else begin
            cs_n <= '1;
            strb <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
            ba   <= '0;
            addr <= '0;
        end
    end

    p_cs_only_on_issue_r8: assert property (@(posedge clk) disable iff (rst)
        !issue |=> (cs_n == '1));

    p_cs_follows_mask_r2: assert property (@(posedge clk) disable iff (rst)
        issue |=> ((~cs_n) == $past(cmd.mask)));

endmodule

// File: rtl/sdram_cmd_exec.sv
module sdram_cmd_exec
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic [27:0]       tim_bank1,
    input  logic [27:0]       tim_bank2,
    output logic [31:0]       status,
    output logic [1:0]        sd_cke,
    output logic [1:0]        sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);
    cmd_s               dec_cmd;
    logic               dec_legal;
    logic [FIELD_W-1:0] dec_gap;
    logic               issue;
    cmd_s               issue_cmd;
    logic               busy;
    strobe_s            strb;

    sdcmd_decode u_dec (
        .word   (wr_data),
        .tim_b1 (tim_bank1),
        .tim_b2 (tim_bank2),
        .cmd    (dec_cmd),
        .legal  (dec_legal),
        .gap    (dec_gap)
    );

    sdcmd_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .legal     (dec_legal),
        .cmd_in    (dec_cmd),
        .gap_in    (dec_gap),
        .issue     (issue),
        .issue_cmd (issue_cmd),
        .busy      (busy)
    );

    sdcmd_pins #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_pins (
        .clk  (clk),
        .rst  (rst),
        .issue(issue),
        .cmd  (issue_cmd),
        .cke  (sd_cke),
        .cs_n (sd_cs_n),
        .strb (strb),
        .ba   (sd_ba),
        .addr (sd_addr)
    );

    assign sd_ras_n = strb.ras_n;
    assign sd_cas_n = strb.cas_n;
    assign sd_we_n  = strb.we_n;

    always_comb begin
        status = '0;
        status[BUSY_BIT] = busy;
    end

    p_idle_deselect_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sd_cs_n == 2'b11));

    p_lmr_payload_r5: assert property (@(posedge clk) disable iff (rst)
        (issue && issue_cmd.mode == MD_LMR)
            |=> (sd_addr == $past(issue_cmd.payload[ADDR_W-1:0])) && (sd_ba == '0));

    p_self_cke_low_r7: assert property (@(posedge clk) disable iff (rst)
        (issue && issue_cmd.mode == MD_SELF && issue_cmd.mask[0]) |=> !sd_cke[0]);

    p_clken_cke_high_r6: assert property (@(posedge clk) disable iff (rst)
        (issue && issue_cmd.mode == MD_CLKEN && issue_cmd.mask[1]) |=> sd_cke[1]);

    p_issue_sets_busy_r12: assert property (@(posedge clk) disable iff (rst)
        issue |=> status[BUSY_BIT]);

endmodule

// File: tb/sdram_cmd_exec_test.sv
`timescale 1ns/1ps
module sdram_cmd_exec_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    // bank1: tMRD=2 tRC=3 tRP=4 ; bank2: tMRD=5 tRC=1 tRP=6
    logic [27:0] tim_bank1 = 28'h040_3002;
    logic [27:0] tim_bank2 = 28'h060_1005;
    logic [31:0] status;
    logic [1:0]  sd_cke, sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    int n_chk = 0;
    int n_fail = 0;

    // watch results
    int busy_len, n_cmds, gap12;
    logic [1:0]  f_cs, f_cke;
    logic [2:0]  f_strb;
    logic [12:0] f_addr;
    logic [1:0]  f_ba;

    sdram_cmd_exec uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .tim_bank1(tim_bank1), .tim_bank2(tim_bank2), .status(status),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Starts on the negedge after the accepting edge; runs while busy
    task automatic watch();
        int cyc = 0;
        int first = 0;
        busy_len = 0; n_cmds = 0; gap12 = 0;
        f_cs = 2'b11; f_cke = sd_cke; f_strb = 3'b111; f_addr = '0; f_ba = '0;
        while (status[5] === 1'b1 && cyc < 1000) begin
            if (sd_cs_n != 2'b11) begin
                n_cmds++;
                if (n_cmds == 1) begin
                    first = cyc;
                    f_cs = sd_cs_n; f_cke = sd_cke;
                    f_strb = {sd_ras_n, sd_cas_n, sd_we_n};
                    f_addr = sd_addr; f_ba = sd_ba;
                end else if (n_cmds == 2) begin
                    gap12 = cyc - first;
                end
            end
            busy_len++;
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk("R1 cke", {30'b0, sd_cke}, 32'h0);
        chk("R1 cs_n", {30'b0, sd_cs_n}, 32'h3);
        chk("R1 busy", status, 32'h0);
    endtask

    task automatic t_clken_both();
        write_word(32'h0000_0019);
        watch();
        chk("R6 clken busy len", busy_len, 1);
        chk("R6 clken cs", {30'b0, f_cs}, 32'h0);
        chk("R6 clken nop strobes", {29'b0, f_strb}, 32'h7);
        chk("R6 clken cke", {30'b0, sd_cke}, 32'h3);
    endtask

    task automatic t_prech_b1();
        write_word(32'h0000_0012);
        chk("R12 status busy", status, 32'h20);
        watch();
        chk("R3 busy len tRP+1", busy_len, 5);
        chk("R3 strobes", {29'b0, f_strb}, 32'h2);
        chk("R3 addr bit10", {19'b0, f_addr}, 32'h400);
        chk("R2 bank1 only cs", {30'b0, f_cs}, 32'h2);
        chk("R8 idle cs", {30'b0, sd_cs_n}, 32'h3);
        chk("R12 status clear", status, 32'h0);
    endtask

    task automatic t_prech_b2();
        write_word(32'h0000_000A);
        watch();
        chk("R3 bank2 busy len", busy_len, 7);
        chk("R2 bank2 only cs", {30'b0, f_cs}, 32'h1);
    endtask

    task automatic t_aref8();
        write_word(32'h0000_00F3);
        watch();
        chk("R4 refresh count", n_cmds, 8);
        chk("R4 spacing tRC+1", gap12, 4);
        chk("R4 busy len", busy_len, 32);
        chk("R4 strobes", {29'b0, f_strb}, 32'h1);
        chk("R4 cke high", {30'b0, f_cke}, 32'h3);
    endtask

    task automatic t_aref_both();
        write_word(32'h0000_003B);
        watch();
        chk("R11 refresh count", n_cmds, 2);
        chk("R11 spacing max tRC", gap12, 4);
        chk("R11 busy len", busy_len, 8);
        chk("R11 both cs", {30'b0, f_cs}, 32'h0);
    endtask

    task automatic t_prech_both();
        write_word(32'h0000_001A);
        watch();
        chk("R11 precharge max tRP", busy_len, 7);
    endtask

    task automatic t_lmr();
        write_word((32'h23 << 9) | 32'h14);
        watch();
        chk("R5 addr payload", {19'b0, f_addr}, 32'h23);
        chk("R5 ba", {30'b0, f_ba}, 32'h0);
        chk("R5 strobes", {29'b0, f_strb}, 32'h0);
        chk("R5 busy tMRD+1", busy_len, 3);
    endtask

    task automatic t_busy_ignore();
        write_word(32'h0000_0012);
        wr_en = 1'b1;
        wr_data = 32'h0000_00F3;
        @(negedge clk);
        wr_en = 1'b0;
        watch();
        chk("R9 no extra command", n_cmds, 0);
        chk("R9 busy unchanged", busy_len, 4);
        repeat (3) @(negedge clk);
        chk("R9 pins idle after", {30'b0, sd_cs_n}, 32'h3);
        chk("R9 still idle", status, 32'h0);
    endtask

    task automatic t_noop();
        write_word(32'h0000_001F);
        chk("R10 mode7 no busy", status, 32'h0);
        chk("R10 mode7 no cs", {30'b0, sd_cs_n}, 32'h3);
        write_word(32'h0000_0002);
        chk("R10 no bank no busy", status, 32'h0);
        chk("R10 no bank no cs", {30'b0, sd_cs_n}, 32'h3);
    endtask

    task automatic t_self_b1();
        write_word(32'h0000_0015);
        watch();
        chk("R7 self cke", {30'b0, f_cke}, 32'h2);
        chk("R7 self strobes", {29'b0, f_strb}, 32'h1);
        chk("R7 self cs", {30'b0, f_cs}, 32'h2);
    endtask

    task automatic t_normal_b1();
        write_word(32'h0000_0010);
        watch();
        chk("R6 normal busy len", busy_len, 1);
        chk("R6 normal cke", {30'b0, sd_cke}, 32'h3);
    endtask

    task automatic t_pdown_b2();
        write_word(32'h0000_000E);
        watch();
        chk("R7 pdown cke", {30'b0, f_cke}, 32'h1);
        chk("R7 pdown nop", {29'b0, f_strb}, 32'h7);
        chk("R7 pdown cs", {30'b0, f_cs}, 32'h1);
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_clken_both();
        t_prech_b1();
        t_prech_b2();
        t_aref8();
        t_aref_both();
        t_prech_both();
        t_lmr();
        t_busy_ignore();
        t_noop();
        t_self_b1();
        t_normal_b1();
        t_pdown_b2();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule